// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Register

This block holds one byte-wide interrupt vector register on a simple synchronous processor bus. In an ordinary bus cycle it acts as plain storage. A write to its address stores the byte, and a read returns the same byte unchanged. The register answers only at address 0x18.

When the interrupt logic has a service request pending and the processor acknowledges it, the block answers with a composed vector instead of the stored byte. The upper five bits of the vector come from the register. The lower three bits come from a service-type code supplied by the interrupt-source logic. Software can therefore give each device a vector base, and the hardware fills in the reason for the interrupt. The same three bits can also carry a device number when several such blocks are chained.

Bus requests are sampled on a rising clock edge, and read data and its output enable appear on the next edge. The output enable stays high for as long as a read or an acknowledge is being answered, and low at all other times, so that an external tri-state buffer can be steered by it.

Top module: `vec_intr_reg`

## Requirements
- R1: After reset the stored byte is 0x00 and the output enable `rdata_oe` is low.
- R2: A cycle with `cs`=1, `addr`=0x18 and `wr_en`=1, outside an acknowledge, stores `wdata` at that clock edge.
- R3: A write with `cs`=0 or with any address other than 0x18 leaves the stored byte unchanged, as later reads show.
- R4: A read at 0x18 (`cs`=1, `rd_en`=1, no acknowledge) gives `rdata_oe`=1 and `rdata` equal to all eight stored bits one cycle later.
- R5: An acknowledge cycle exists only while both `ack_n` and `svc_req_n` are low. Either one low on its own produces no vector.
- R6: From the cycle after an acknowledge begins, and for as long as it lasts, `rdata_oe`=1 and `rdata` = {stored bits 7:3, service code}. Stored bits 2:0 never appear in the vector.
- R7: The service code is captured in the first acknowledge cycle and held until the acknowledge ends. Later changes on `svc_code` do not alter the vector.
- R8: When the previous cycle held neither a matching read nor an acknowledge, `rdata_oe` is 0.
- R9: A write that arrives while an acknowledge is active is ignored.
- R10: A read during an acknowledge returns the vector, not the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for the bus cycle |
| addr | input | 8 | Bus address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| ack_n | input | 1 | Active-low interrupt acknowledge from the processor |
| svc_req_n | input | 1 | Active-low service request from the interrupt logic |
| svc_code | input | 3 | Service-type code or device number |
| rdata | output | 8 | Read data or composed vector |
| rdata_oe | output | 1 | Output enable for the data bus driver |

## Verification
The assertions assume a single-cycle bus protocol in which every request is sampled on one rising edge and answered on the next edge. They also assume that `ack_n` and `svc_req_n` are held steady within a clock period. The stimulus drives every input just after a rising edge and holds it for the whole period. Random stimulus points most cycles at address 0x18 and holds acknowledges for several cycles, while `svc_code` changes freely. This exercises the capture-and-hold rule (R7) as well as the blocking of writes during an acknowledge (R9).

// File: rtl/vec_intr_pkg.sv
package vec_intr_pkg;
    localparam int VEC_DATA_W = 8;
    localparam int VEC_CODE_W = 3;
    localparam int VEC_BASE_W = VEC_DATA_W - VEC_CODE_W;

    typedef logic [VEC_DATA_W-1:0] vec_byte_t;
    typedef logic [VEC_CODE_W-1:0] vec_code_t;

    typedef struct packed {
        logic      active;
        vec_code_t code;
    } ack_state_t;

    typedef struct packed {
        logic      oe;
        vec_byte_t data;
    } bus_state_t;
endpackage

// File: rtl/vec_decode.sv
module vec_decode #(
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h18
) (
    input  logic              cs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              ack_active,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic sel;

    always_comb begin
        sel    = cs && (addr == REG_ADDR);
        wr_hit = sel && wr_en && !ack_active;
        rd_hit = sel && rd_en && !ack_active;
    end
endmodule

// File: rtl/vec_ack_track.sv
module vec_ack_track
    import vec_intr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ack_n,
    input  logic      svc_req_n,
    input  vec_code_t svc_code,
    output logic      ack_active,
    output vec_code_t code_d_o
);
    ack_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        ack_active  = !ack_n && !svc_req_n;
        st_d.active = ack_active;
        if (ack_active && !st_q.active) begin
            st_d.code = svc_code;
        end
        code_d_o = st_d.code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_active && st_q.active) |=> $stable(st_q.code));
endmodule

// File: rtl/vec_store.sv
module vec_store
    import vec_intr_pkg::*;
#(
    parameter vec_byte_t RESET_VAL = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hit,
    input  vec_byte_t wdata,
    output vec_byte_t reg_q_o
);
    vec_byte_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_hit) begin
            reg_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= RESET_VAL;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign reg_q_o = reg_q;

    // R3
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(reg_q));
endmodule

// File: rtl/vec_bus_out.sv
module vec_bus_out
    import vec_intr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ack_active,
    input  logic      rd_hit,
    input  vec_byte_t reg_q,
    input  vec_code_t code_d,
    output vec_byte_t rdata,
    output logic      rdata_oe
);
    bus_state_t bus_d, bus_q;

    always_comb begin
        bus_d = '0;
        if (ack_active) begin
            bus_d.oe   = 1'b1;
            bus_d.data = {reg_q[VEC_DATA_W-1:VEC_CODE_W], code_d};
        end else if (rd_hit) begin
            bus_d.oe   = 1'b1;
            bus_d.data = reg_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign rdata    = bus_q.data;
    assign rdata_oe = bus_q.oe;

    // R8
    idle_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_active && !rd_hit) |=> !rdata_oe);
endmodule

// File: rtl/vec_intr_reg.sv
module vec_intr_reg
    import vec_intr_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h18,
    parameter vec_byte_t         RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    input  logic              ack_n,
    input  logic              svc_req_n,
    input  logic [2:0]        svc_code,
    output logic [7:0]        rdata,
    output logic              rdata_oe
);
    logic      ack_active;
    logic      wr_hit;
    logic      rd_hit;
    vec_code_t code_d;
    vec_byte_t reg_q;

    vec_ack_track u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_n      (ack_n),
        .svc_req_n  (svc_req_n),
        .svc_code   (svc_code),
        .ack_active (ack_active),
        .code_d_o   (code_d)
    );

    vec_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .cs         (cs),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .ack_active (ack_active),
        .wr_hit     (wr_hit),
        .rd_hit     (rd_hit)
    );

    vec_store #(.RESET_VAL(RESET_VAL)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (wdata),
        .reg_q_o (reg_q)
    );

    vec_bus_out u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_active (ack_active),
        .rd_hit     (rd_hit),
        .reg_q      (reg_q),
        .code_d     (code_d),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe)
    );

    // R4
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && addr == REG_ADDR && rd_en && ack_n) |=> (rdata_oe && rdata == $past(reg_q)));

    // R6
    vec_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !svc_req_n) |=>
        (rdata_oe && rdata[7:VEC_CODE_W] == $past(reg_q[7:VEC_CODE_W])));

    // R9
    ack_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !svc_req_n && wr_en) |=> $stable(reg_q));
endmodule

// File: tb/test_vec_intr_reg.sv
module test_vec_intr_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic       ack_n = 1'b1, svc_req_n = 1'b1;
    logic [2:0] svc_code = '0;
    logic [7:0] rdata;
    logic       rdata_oe;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] m_reg;
    logic [2:0] m_code;
    logic       m_ack_prev;
    logic       exp_oe;
    logic [7:0] exp_data;
    string      exp_tag;

    always #4 clk = ~clk;

    vec_intr_reg i_vec_intr_reg (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .ack_n(ack_n), .svc_req_n(svc_req_n),
        .svc_code(svc_code), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    function automatic logic [7:0] compose_vec(logic [7:0] r, logic [2:0] c);
        return {r[7:3], c};
    endfunction

    // Reference model step: uses inputs set for this edge and model state.
    task automatic model_step();
        logic ack, hit;
        ack = !ack_n && !svc_req_n;
        hit = cs && (addr == 8'h18);
        if (ack) begin
            if (!m_ack_prev) m_code = svc_code;
            exp_oe = 1'b1;
            exp_data = compose_vec(m_reg, m_code);
            exp_tag = "R6";
        end else if (hit && rd_en) begin
            exp_oe = 1'b1;
            exp_data = m_reg;
            exp_tag = "R4";
        end else begin
            exp_oe = 1'b0;
            exp_data = 'x;
            exp_tag = "R8";
        end
        if (!ack && hit && wr_en) m_reg = wdata;
        m_ack_prev = ack;
    endtask

    task automatic check_out(string tag);
        n_checks++;
        if (rdata_oe !== exp_oe || (exp_oe && rdata !== exp_data)) begin
            n_errors++;
            $display("FAIL %s: actual oe=%0b data=%02h expected oe=%0b data=%02h",
                     tag, rdata_oe, rdata, exp_oe, exp_data);
        end
    endtask

    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        #1;
        check_out(tag);
    endtask

    task automatic idle_bus();
        cs = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        ack_n = 1; svc_req_n = 1;
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d, logic sel, string tag);
        idle_bus(); cs = sel; addr = a; wr_en = 1; wdata = d;
        tick(tag);
    endtask

    task automatic do_read(string tag);
        idle_bus(); cs = 1; addr = 8'h18; rd_en = 1;
        tick(tag);
    endtask

    initial begin
        m_reg = 8'h00; m_code = '0; m_ack_prev = 0;
        exp_oe = 0; exp_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        n_checks++;
        if (rdata_oe !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: actual oe=%0b expected oe=0", rdata_oe);
        end
        do_read("R1");

        // R2 / R4: write then read back
        do_write(8'h18, 8'hA5, 1, "R2");
        do_read("R2");
        do_write(8'h18, 8'hFF, 1, "R2");
        do_read("R4");

        // R3: other address and deselected writes ignored
        do_write(8'h19, 8'h00, 1, "R3");
        do_write(8'h18, 8'h12, 0, "R3");
        do_read("R3");

        // R5: only one of the two strobes low
        idle_bus(); ack_n = 0; svc_code = 3'd5; tick("R5");
        idle_bus(); svc_req_n = 0; svc_code = 3'd5; tick("R5");

        // R6: every service code, low stored bits must not leak
        do_write(8'h18, 8'b1011_0111, 1, "R6");
        for (int c = 0; c < 8; c++) begin
            idle_bus(); ack_n = 0; svc_req_n = 0; svc_code = c[2:0];
            tick("R6");
            tick("R6");
            idle_bus(); tick("R8");
        end

        // R7: code changes mid-acknowledge are not seen
        idle_bus(); ack_n = 0; svc_req_n = 0; svc_code = 3'd2; tick("R7");
        svc_code = 3'd6; tick("R7");
        svc_code = 3'd1; tick("R7");

        // R9: write during acknowledge ignored
        cs = 1; addr = 8'h18; wr_en = 1; wdata = 8'h00; tick("R9");
        // R10: read during acknowledge returns vector
        wr_en = 0; rd_en = 1; tick("R10");
        idle_bus(); tick("R8");
        do_read("R9");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 9);
            idle_bus();
            cs = ($urandom_range(0, 7) != 0);
            addr = ($urandom_range(0, 3) != 0) ? 8'h18 : 8'($urandom);
            wdata = 8'($urandom);
            svc_code = 3'($urandom);
            if (op < 3) wr_en = 1;
            else if (op < 6) rd_en = 1;
            else if (op == 6) begin wr_en = 1; rd_en = 1; end
            if (op >= 7 || m_ack_prev && $urandom_range(0, 2) != 0) begin
                ack_n = 0; svc_req_n = ($urandom_range(0, 5) == 0);
            end else if ($urandom_range(0, 9) == 0) begin
                ack_n = $urandom_range(0, 1); svc_req_n = !ack_n;
            end
            tick("RND");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1283));
    end
endmodule